// File: doc/BRIEF.md
# Contiguous Buffer Bank Allocator

This block hands out space in a shared message memory that is split into a fixed number of equal banks (four by default). A requester presents a byte length together with the current bank size; the block works out how many banks that length occupies, rounding up, and reserves the lowest-placed run of that many adjacent free banks. Alongside the banks it keeps a small pool of message slots (four by default) and reserves the lowest free one with every successful allocation. A failed allocation reserves nothing. A one-cycle free request returns a slot and a set of banks together.

The control is a four-state machine. `S_IDLE` waits for `alloc_req`. If the length exceeds the whole buffer, it goes straight to `S_RESULT` with a length error. If the length is zero, it goes to `S_SEARCH`. Otherwise it goes to `S_COUNT`. `S_COUNT` subtracts the bank size once per cycle and counts one bank per pass. It moves to `S_SEARCH` once the remainder fits in one bank. `S_SEARCH` looks at the maps as they stand after any free request in the same cycle, decides the outcome and commits the reservation. It then always moves to `S_RESULT`. `S_RESULT` raises `alloc_gnt` for exactly one cycle and always returns to `S_IDLE`. The requester holds `alloc_req` and its length until it sees `alloc_gnt`. `alloc_req` is only looked at in `S_IDLE`.

Top module: `bank_run_alloc`

## Requirements
- R1: The number of banks reserved equals ceil(length / bank_size); the granted mask has exactly that many bits set.
- R2: The granted banks are adjacent. The run starts at the lowest start position whose banks are all free, so a mask such as 0110 may be granted but 0101 never is.
- R3: A zero length completes with status OK (0), an all-zero bank mask and a slot reserved, and leaves the bank map unchanged.
- R4: When no run of the needed size is free, the status is no-buffer (3), the mask is zero and neither the bank map nor the slot map changes.
- R5: The granted slot is the lowest-numbered clear bit of the slot map. When all slot bits are set, the status is no-slot (2) and neither map changes. No-slot is checked before no-buffer.
- R6: A free request clears bit `free_slot` of the slot map and every bank bit set in `free_mask`, taking effect at the next clock edge.
- R7: A length greater than NUM_BANKS × bank_size completes with status length-error (1), with no further processing and no change to either map.
- R8: `alloc_full` is 1 with a successful grant exactly when the length equals NUM_BANKS × bank_size. This exposes the case in which an 11-bit halfword length field would wrap to 0.
- R9: A free request in the same cycle as the search is applied first, so that search can use the released banks and slot.
- R10: After reset both maps are clear and `alloc_gnt` is low. `alloc_gnt` is a single-cycle pulse, and the result outputs are valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alloc_req | input | 1 | Allocation request, held until `alloc_gnt` |
| alloc_len | input | LEN_W | Requested length in bytes |
| bank_size | input | SIZE_W | Size of one bank in bytes |
| free_req | input | 1 | Single-cycle release request |
| free_slot | input | SLOT_W | Slot to release |
| free_mask | input | NUM_BANKS | Banks to release |
| alloc_gnt | output | 1 | One-cycle completion pulse |
| alloc_status | output | 2 | 0 OK, 1 length error, 2 no slot, 3 no buffer |
| alloc_slot | output | SLOT_W | Granted slot index |
| alloc_mask | output | NUM_BANKS | Granted bank mask, zero on failure |
| alloc_full | output | 1 | Length equals the whole buffer |
| bank_busy | output | NUM_BANKS | Current reserved-bank map |
| slot_busy | output | NUM_SLOTS | Current reserved-slot map |

## Verification
A wrong bank count in `S_COUNT`, or a wrong start position in the run search, shows up in `alloc_mask` on the grant pulse. That pulse comes 3 to 6 cycles after the request, and `bank_busy` changes on the same edge. A map that fails to clear, or that leaks bits, is visible on `bank_busy` or `slot_busy` one cycle after the free request. It also shows up as a wrong choice of run or slot on the next allocation. Ordering faults between free and search show up only when the two fall in the same cycle, so that case is driven at an exact cycle offset.

// File: rtl/bank_alloc_pkg.sv
package bank_alloc_pkg;

    typedef enum logic [1:0] {
        ST_OK       = 2'd0,
        ST_LEN_ERR  = 2'd1,
        ST_NO_SLOT  = 2'd2,
        ST_NO_BUF   = 2'd3
    } alloc_status_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_COUNT,
        S_SEARCH,
        S_RESULT
    } alloc_state_e;

endpackage

// File: rtl/bank_run_finder.sv
module bank_run_finder #(
    parameter int NB     = 4,
    parameter int NEED_W = 3
) (
    input  logic [NB-1:0]     busy,
    input  logic [NEED_W-1:0] need,
    output logic              found,
    output logic [NB-1:0]     mask
);
    logic [NB-1:0] ones;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            ones[i] = (i < int'(need));
        end
    end

    // lowest start position whose whole window is free
    always_comb begin
        found = 1'b0;
        mask  = '0;
        for (int s = 0; s < NB; s++) begin
            if (!found && (s + int'(need) <= NB) && (((ones << s) & busy) == '0)) begin
                found = 1'b1;
                mask  = ones << s;
            end
        end
    end
endmodule

// File: rtl/slot_picker.sv
module slot_picker #(
    parameter int NS     = 4,
    parameter int SLOT_W = 2
) (
    input  logic [NS-1:0]     busy,
    output logic              found,
    output logic [SLOT_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NS - 1; i >= 0; i--) begin
            if (!busy[i]) begin
                found = 1'b1;
                idx   = SLOT_W'(i);
            end
        end
    end
endmodule

// File: rtl/alloc_maps.sv
module alloc_maps #(
    parameter int NB     = 4,
    parameter int NS     = 4,
    parameter int SLOT_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              free_req,
    input  logic [SLOT_W-1:0] free_slot,
    input  logic [NB-1:0]     free_mask,
    input  logic              take_en,
    input  logic [SLOT_W-1:0] take_slot,
    input  logic [NB-1:0]     take_mask,
    output logic [NB-1:0]     bank_busy,
    output logic [NS-1:0]     slot_busy,
    output logic [NB-1:0]     bank_view,
    output logic [NS-1:0]     slot_view
);
    logic [NS-1:0] free_oh;
    logic [NS-1:0] take_oh;

    // release is folded in before any reservation looks at the maps
    always_comb begin
        free_oh   = free_req ? (NS'(1) << free_slot) : '0;
        take_oh   = take_en  ? (NS'(1) << take_slot) : '0;
        bank_view = bank_busy & ~(free_req ? free_mask : '0);
        slot_view = slot_busy & ~free_oh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_busy <= '0;
            slot_busy <= '0;
        end else begin
            bank_busy <= bank_view | (take_en ? take_mask : '0);
            slot_busy <= slot_view | take_oh;
        end
    end
endmodule

// File: rtl/bank_run_alloc.sv
module bank_run_alloc
    import bank_alloc_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_SLOTS = 4,
    parameter int LEN_W     = 13,
    parameter int SIZE_W    = 11,
    parameter int SLOT_W    = $clog2(NUM_SLOTS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 alloc_req,
    input  logic [LEN_W-1:0]     alloc_len,
    input  logic [SIZE_W-1:0]    bank_size,
    input  logic                 free_req,
    input  logic [SLOT_W-1:0]    free_slot,
    input  logic [NUM_BANKS-1:0] free_mask,
    output logic                 alloc_gnt,
    output logic [1:0]           alloc_status,
    output logic [SLOT_W-1:0]    alloc_slot,
    output logic [NUM_BANKS-1:0] alloc_mask,
    output logic                 alloc_full,
    output logic [NUM_BANKS-1:0] bank_busy,
    output logic [NUM_SLOTS-1:0] slot_busy
);
    localparam int NEED_W = $clog2(NUM_BANKS + 1);
    localparam int PROD_W = SIZE_W + NEED_W;
    localparam int CMP_W  = (LEN_W > PROD_W) ? LEN_W : PROD_W;

    alloc_state_e st, st_nx;

    logic [CMP_W-1:0]  len_ext, full_ext;
    logic [CMP_W-1:0]  rem_q, size_q;
    logic [NEED_W-1:0] need_q;
    logic              full_hit_q;
    logic              len_too_big;

    logic [NUM_BANKS-1:0] bank_view, run_mask;
    logic [NUM_SLOTS-1:0] slot_view;
    logic                 run_found, slot_found, take_en;
    logic [SLOT_W-1:0]    slot_idx;

    alloc_status_e        status_q;
    logic [SLOT_W-1:0]    slot_q;
    logic [NUM_BANKS-1:0] mask_q;
    logic                 full_q;

    assign len_ext     = CMP_W'(alloc_len);
    assign full_ext    = CMP_W'(bank_size) * CMP_W'(NUM_BANKS);
    assign len_too_big = len_ext > full_ext;
    assign take_en     = (st == S_SEARCH) && slot_found && run_found;

    alloc_maps #(
        .NB     (NUM_BANKS),
        .NS     (NUM_SLOTS),
        .SLOT_W (SLOT_W)
    ) u_maps (
        .clk       (clk),
        .rst_n     (rst_n),
        .free_req  (free_req),
        .free_slot (free_slot),
        .free_mask (free_mask),
        .take_en   (take_en),
        .take_slot (slot_idx),
        .take_mask (run_mask),
        .bank_busy (bank_busy),
        .slot_busy (slot_busy),
        .bank_view (bank_view),
        .slot_view (slot_view)
    );

    bank_run_finder #(
        .NB     (NUM_BANKS),
        .NEED_W (NEED_W)
    ) u_finder (
        .busy  (bank_view),
        .need  (need_q),
        .found (run_found),
        .mask  (run_mask)
    );

    slot_picker #(
        .NS     (NUM_SLOTS),
        .SLOT_W (SLOT_W)
    ) u_picker (
        .busy  (slot_view),
        .found (slot_found),
        .idx   (slot_idx)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= st_nx;
    end

    // transitions
    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: begin
                if (alloc_req) begin
                    if (len_too_big)         st_nx = S_RESULT;
                    else if (len_ext == '0)  st_nx = S_SEARCH;
                    else                     st_nx = S_COUNT;
                end
            end
            S_COUNT:  if (rem_q <= size_q) st_nx = S_SEARCH;
            S_SEARCH: st_nx = S_RESULT;
            S_RESULT: st_nx = S_IDLE;
            default:  st_nx = S_IDLE;
        endcase
    end

    // working registers and registered results
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q      <= '0;
            size_q     <= '0;
            need_q     <= '0;
            full_hit_q <= 1'b0;
            status_q   <= ST_OK;
            slot_q     <= '0;
            mask_q     <= '0;
            full_q     <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (alloc_req) begin
                        rem_q      <= len_ext;
                        size_q     <= CMP_W'(bank_size);
                        need_q     <= '0;
                        full_hit_q <= (len_ext == full_ext) && (len_ext != '0);
                        if (len_too_big) begin
                            status_q <= ST_LEN_ERR;
                            slot_q   <= '0;
                            mask_q   <= '0;
                            full_q   <= 1'b0;
                        end
                    end
                end
                S_COUNT: begin
                    need_q <= need_q + NEED_W'(1);
                    if (rem_q > size_q) rem_q <= rem_q - size_q;
                end
                S_SEARCH: begin
                    if (!slot_found) begin
                        status_q <= ST_NO_SLOT;
                        slot_q   <= '0;
                        mask_q   <= '0;
                        full_q   <= 1'b0;
                    end else if (!run_found) begin
                        status_q <= ST_NO_BUF;
                        slot_q   <= '0;
                        mask_q   <= '0;
                        full_q   <= 1'b0;
                    end else begin
                        status_q <= ST_OK;
                        slot_q   <= slot_idx;
                        mask_q   <= run_mask;
                        full_q   <= full_hit_q;
                    end
                end
                S_RESULT: ;
                default:  ;
            endcase
        end
    end

    assign alloc_gnt    = (st == S_RESULT);
    assign alloc_status = status_q;
    assign alloc_slot   = slot_q;
    assign alloc_mask   = mask_q;
    assign alloc_full   = full_q;

endmodule

// File: rtl/bank_run_alloc_chk.sv
module bank_run_alloc_chk #(
    parameter int NB     = 4,
    parameter int NS     = 4,
    parameter int SLOT_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              free_req,
    input logic              alloc_gnt,
    input logic [1:0]        alloc_status,
    input logic [SLOT_W-1:0] alloc_slot,
    input logic [NB-1:0]     alloc_mask,
    input logic [NB-1:0]     bank_busy,
    input logic [NS-1:0]     slot_busy
);
    logic [NB-1:0] low_bit;
    assign low_bit = alloc_mask & (~alloc_mask + NB'(1));

    // R2: granted run has no holes
    assert_run_adjacent_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_status == 2'd0) |-> (((alloc_mask + low_bit) & alloc_mask) == '0));

    // R1: granted banks and slot are recorded as reserved
    assert_grant_recorded_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_status == 2'd0) |->
            (((bank_busy & alloc_mask) == alloc_mask) && slot_busy[alloc_slot]));

    // R4: a no-buffer outcome does not touch the maps
    assert_nobuf_keeps_maps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_status == 2'd3 && !$past(free_req)) |->
            (bank_busy == $past(bank_busy) && slot_busy == $past(slot_busy)));

    // R4: failed outcomes carry an empty mask
    assert_fail_empty_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_status != 2'd0) |-> (alloc_mask == '0));

    // R5: no-slot only when every slot is taken
    assert_noslot_when_full_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_gnt && alloc_status == 2'd2) |-> (&slot_busy));

    // R10: completion is a single-cycle pulse
    assert_gnt_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_gnt |=> !alloc_gnt);
endmodule

bind bank_run_alloc bank_run_alloc_chk #(
    .NB     (NUM_BANKS),
    .NS     (NUM_SLOTS),
    .SLOT_W (SLOT_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .free_req     (free_req),
    .alloc_gnt    (alloc_gnt),
    .alloc_status (alloc_status),
    .alloc_slot   (alloc_slot),
    .alloc_mask   (alloc_mask),
    .bank_busy    (bank_busy),
    .slot_busy    (slot_busy)
);

// File: tb/bank_run_alloc_bench.sv
module bank_run_alloc_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        alloc_req = 1'b0;
    logic [12:0] alloc_len = '0;
    logic [10:0] bank_size = 11'd64;
    logic        free_req = 1'b0;
    logic [1:0]  free_slot = '0;
    logic [3:0]  free_mask = '0;
    logic        alloc_gnt;
    logic [1:0]  alloc_status;
    logic [1:0]  alloc_slot;
    logic [3:0]  alloc_mask;
    logic        alloc_full;
    logic [3:0]  bank_busy;
    logic [3:0]  slot_busy;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    bank_run_alloc u_bank_run_alloc (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .alloc_len(alloc_len),
        .bank_size(bank_size), .free_req(free_req), .free_slot(free_slot),
        .free_mask(free_mask), .alloc_gnt(alloc_gnt), .alloc_status(alloc_status),
        .alloc_slot(alloc_slot), .alloc_mask(alloc_mask), .alloc_full(alloc_full),
        .bank_busy(bank_busy), .slot_busy(slot_busy)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

    // request, wait for the grant, then compare every result field
    task automatic alloc_chk(input string tag, input int len, input int st,
                             input int slot, input int mask, input int full,
                             input int bb, input int sb);
        int waited = 0;
        alloc_req = 1'b1;
        alloc_len = 13'(len);
        @(negedge clk);
        while (!alloc_gnt && waited < 20) begin
            @(negedge clk);
            waited++;
        end
        alloc_req = 1'b0;
        chk({tag, " gnt R10"}, int'(alloc_gnt), 1);
        chk({tag, " status"}, int'(alloc_status), st);
        chk({tag, " slot R5"}, int'(alloc_slot), slot);
        chk({tag, " mask R1/R2"}, int'(alloc_mask), mask);
        chk({tag, " full R8"}, int'(alloc_full), full);
        chk({tag, " bank map"}, int'(bank_busy), bb);
        chk({tag, " slot map"}, int'(slot_busy), sb);
        @(negedge clk);
        chk({tag, " pulse R10"}, int'(alloc_gnt), 0);
    endtask

    task automatic free_chk(input string tag, input int slot, input int mask,
                            input int bb, input int sb);
        free_req  = 1'b1;
        free_slot = 2'(slot);
        free_mask = 4'(mask);
        @(negedge clk);
        free_req  = 1'b0;
        chk({tag, " bank map R6"}, int'(bank_busy), bb);
        chk({tag, " slot map R6"}, int'(slot_busy), sb);
    endtask

    task automatic t_reset();
        chk("reset gnt R10", int'(alloc_gnt), 0);
        chk("reset banks R10", int'(bank_busy), 0);
        chk("reset slots R10", int'(slot_busy), 0);
    endtask

    task automatic t_basic();
        alloc_chk("len100 R1", 100, 0, 0, 'b0011, 0, 'b0011, 'b0001);
        alloc_chk("len64 R2", 64, 0, 1, 'b0100, 0, 'b0111, 'b0011);
        free_chk("free s0", 0, 'b0011, 'b0100, 'b0010);
        alloc_chk("len65 R1", 65, 0, 0, 'b0011, 0, 'b0111, 'b0011);
        free_chk("free s0 again", 0, 'b0011, 'b0100, 'b0010);
    endtask

    task automatic t_gap();
        alloc_chk("len1 R1", 1, 0, 0, 'b0001, 0, 'b0101, 'b0011);
        alloc_chk("nofit R4", 100, 3, 0, 0, 0, 'b0101, 'b0011);
        free_chk("free s1", 1, 'b0100, 'b0001, 'b0001);
        alloc_chk("skip start0 R2", 128, 0, 1, 'b0110, 0, 'b0111, 'b0011);
    endtask

    task automatic t_zero_and_slots();
        alloc_chk("zero len R3", 0, 0, 2, 0, 0, 'b0111, 'b0111);
        alloc_chk("zero len slot3 R3", 0, 0, 3, 0, 0, 'b0111, 'b1111);
        alloc_chk("no slot R5", 1, 2, 0, 0, 0, 'b0111, 'b1111);
        free_chk("free s0", 0, 'b0001, 'b0110, 'b1110);
        free_chk("free s1", 1, 'b0110, 'b0000, 'b1100);
        free_chk("free s2", 2, 0, 'b0000, 'b1000);
        free_chk("free s3", 3, 0, 'b0000, 'b0000);
    endtask

    task automatic t_limits();
        alloc_chk("too long R7", 257, 1, 0, 0, 0, 0, 0);
        alloc_chk("full buffer R8", 256, 0, 0, 'b1111, 1, 'b1111, 'b0001);
    endtask

    // free lands on the exact edge at which the search runs
    task automatic t_free_first();
        alloc_req = 1'b1;
        alloc_len = 13'd10;
        @(negedge clk);
        @(negedge clk);
        free_req  = 1'b1;
        free_slot = 2'd0;
        free_mask = 4'b1111;
        @(negedge clk);
        free_req  = 1'b0;
        alloc_req = 1'b0;
        chk("free-first gnt R9", int'(alloc_gnt), 1);
        chk("free-first status R9", int'(alloc_status), 0);
        chk("free-first mask R9", int'(alloc_mask), 'b0001);
        chk("free-first slot R9", int'(alloc_slot), 0);
        chk("free-first banks R9", int'(bank_busy), 'b0001);
        @(negedge clk);
    endtask

    task automatic t_small_bank();
        bank_size = 11'd16;
        alloc_chk("size16 len33 R1", 33, 0, 1, 'b1110, 0, 'b1111, 'b0011);
        free_chk("free all", 1, 'b1110, 'b0001, 'b0001);
        free_chk("free last", 0, 'b0001, 'b0000, 'b0000);
        alloc_chk("size16 len64 R8", 64, 0, 0, 'b1111, 1, 'b1111, 'b0001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_gap();
        t_zero_and_slots();
        t_limits();
        t_free_first();
        t_small_bank();
        finish_run();
    end
endmodule